// File: doc/BRIEF.md
# Receive DC Offset Corrector

This block strips a constant bias from the in-phase and quadrature sample streams of a receive path. Each of the two channels keeps its own offset estimate and subtracts it from every valid sample. The corrected result is clipped to the signed sample range and appears one clock later.

Each channel is steered by one 32-bit control word, written over a simple write-only bus. The I channel's word sits at byte offset 8 and the Q channel's at byte offset 12. Bit 31 of a word chooses between a fixed offset and automatic tracking. Bit 30 asks for the value field, bits 29:0, to be loaded. In automatic mode the estimate follows the input through a first-order leaky integrator. In fixed mode the estimate stays where it is until software loads a new constant or switches tracking back on. Both estimates are brought out on status ports.

Top module: `rx_dc_corrector`

## Requirements
- R1: A write with `cfg_we` high is taken by the I channel only at `cfg_addr` 8 and by the Q channel only at `cfg_addr` 12. A write to any other address changes neither estimate nor either mode.
- R2: While `rst` is high and after it is released, both channels are in automatic mode, both estimates are zero and `out_valid` is low.
- R3: A write with bit 31 and bit 30 both set loads bits 29:0 as a signed estimate, where 2^29 stands for full scale (+1.0). The new value shows on the channel's estimate port after the next clock edge.
- R4: A write with bit 31 set and bit 30 clear puts the channel in fixed mode and leaves its estimate unchanged, whatever bits 29:0 hold. A channel in fixed mode keeps its estimate across any number of valid samples.
- R5: A write with bit 31 clear puts the channel in automatic mode. In that mode each valid sample x (SAMP_W bits) updates the estimate e by e := e + ((x*2^(30-SAMP_W) - e) >>> 12), where >>> is an arithmetic shift that floors.
- R6: An estimate never changes in a cycle with `in_valid` low and no write addressed to its channel.
- R7: For each valid sample the output one cycle later is x - ((e + 2^(29-SAMP_W)) >>> (30-SAMP_W)), using the estimate held before that cycle's update. `out_valid` is `in_valid` delayed by one cycle.
- R8: Whenever the difference in R7 falls outside [-2^(SAMP_W-1), 2^(SAMP_W-1)-1], the output is clamped to the nearer limit.
- R9: In automatic mode, a constant input held long enough brings the channel's output to exactly zero.
- R10: A write to one channel leaves the other channel's tracking untouched. When a write and a valid sample hit the same channel in the same cycle, the write decides the new estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control word write strobe |
| cfg_addr | input | ADDR_W | Byte offset of the written word |
| cfg_wdata | input | 32 | Control word: bit 31 fixed, bit 30 load, bits 29:0 signed value |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | SAMP_W | Signed in-phase sample |
| in_q | input | SAMP_W | Signed quadrature sample |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | SAMP_W | Corrected, saturated in-phase sample |
| out_q | output | SAMP_W | Corrected, saturated quadrature sample |
| est_i | output | 30 | Current in-phase offset estimate |
| est_q | output | 30 | Current quadrature offset estimate |

## Verification
The bench drives the block to its sharpest corners. It loads offsets of exactly -1.0 and just under +1.0 against full-scale samples of the opposite sign, so a design without the extra headroom bit would wrap around instead of clamping. It freezes one channel with a non-zero value field, so a design that loaded on bit 31 alone would jump. It aims a load and a valid sample at the same channel in one cycle, so a design that let tracking win would miss the loaded value. It also writes to neighbouring offsets 4 and 16, and holds one channel at a constant positive bias and the other at a constant negative bias until both outputs settle to zero. A design whose estimate creeps upward or never settles, for example by truncating where it should round, leaves a residue of one code on one of the two channels.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;
   // width of the offset value field; 2^(VAL_W-1) is full scale
   localparam int VAL_W     = 30;
   // byte offset of the I channel word and spacing to the Q word
   localparam int OFS_FIRST = 8;
   localparam int OFS_STEP  = 4;
   localparam int N_CH      = 2;

   typedef struct packed {
      logic                    fixed;
      logic                    load;
      logic signed [VAL_W-1:0] value;
   } ctl_word_t;
endpackage

// File: rtl/dcoc_satsub.sv
module dcoc_satsub #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W:0]   b,
   output logic [W-1:0] y
);
   localparam int DW = W + 2;
   localparam logic signed [DW-1:0] MAXV = DW'((64'sd1 <<< (W - 1)) - 64'sd1);
   localparam logic signed [DW-1:0] MINV = -MAXV - DW'(1);

   logic signed [DW-1:0] d;

   assign d = DW'(signed'(a)) - DW'(signed'(b));

   always_comb begin
      if (d > MAXV)      y = MAXV[W-1:0];
      else if (d < MINV) y = MINV[W-1:0];
      else               y = d[W-1:0];
   end
endmodule

// File: rtl/dcoc_chan.sv
module dcoc_chan
   import dcoc_pkg::*;
#(
   parameter int SAMP_W  = 16,
   parameter int SHIFT_K = 12,
   parameter int ADDR_W  = 5,
   parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              in_valid,
   input  logic [SAMP_W-1:0] in_x,
   output logic [SAMP_W-1:0] out_x,
   output logic [VAL_W-1:0]  est
);
   localparam int FRAC = VAL_W - SAMP_W;
   localparam int WIDE = VAL_W + 1;
   localparam logic signed [WIDE-1:0] HALF = WIDE'(1) <<< (FRAC - 1);

   ctl_word_t              w;
   logic                   hit, do_load, do_track, fixed_q;
   logic signed [VAL_W-1:0] est_q, est_d, x_sc;
   logic signed [WIDE-1:0]  diff, step, rnd_w;
   logic [SAMP_W-1:0]       sub_y, out_q;

   assign w        = ctl_word_t'(cfg_wdata);
   assign hit      = cfg_we && (cfg_addr == MY_ADDR);
   assign do_load  = hit && w.fixed && w.load;
   assign do_track = in_valid && !fixed_q && !(hit && w.fixed);

   // sample lifted into the value-field scale
   assign x_sc = {in_x, {FRAC{1'b0}}};
   assign diff = WIDE'(x_sc) - WIDE'(est_q);
   assign step = diff >>> SHIFT_K;

   always_comb begin
      est_d = est_q;
      if (do_load)       est_d = w.value;
      else if (do_track) est_d = VAL_W'(WIDE'(est_q) + step);
   end

   // estimate rounded to sample scale
   assign rnd_w = (WIDE'(est_q) + HALF) >>> FRAC;

   dcoc_satsub #(.W(SAMP_W)) u_sub (
      .a (in_x),
      .b (rnd_w[SAMP_W:0]),
      .y (sub_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         est_q   <= '0;
         fixed_q <= 1'b0;
         out_q   <= '0;
      end else begin
         est_q <= est_d;
         if (hit)      fixed_q <= w.fixed;
         if (in_valid) out_q   <= sub_y;
      end
   end

   assign est   = est_q;
   assign out_x = out_q;

   assert_load_R3: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_addr == MY_ADDR && cfg_wdata[31] && cfg_wdata[30])
      |=> (est == $past(cfg_wdata[VAL_W-1:0])));

   assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
      (fixed_q && !(cfg_we && cfg_addr == MY_ADDR)) |=> $stable(est));

   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !(cfg_we && cfg_addr == MY_ADDR)) |=> $stable(est));

   assert_zero_pass_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && rnd_w == '0) |=> (out_x == $past(in_x)));
endmodule

// File: rtl/rx_dc_corrector.sv
module rx_dc_corrector
   import dcoc_pkg::*;
#(
   parameter int SAMP_W  = 16,
   parameter int SHIFT_K = 12,
   parameter int ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              in_valid,
   input  logic [SAMP_W-1:0] in_i,
   input  logic [SAMP_W-1:0] in_q,
   output logic              out_valid,
   output logic [SAMP_W-1:0] out_i,
   output logic [SAMP_W-1:0] out_q,
   output logic [VAL_W-1:0]  est_i,
   output logic [VAL_W-1:0]  est_q
);
   localparam int LAST_OFS = OFS_FIRST + OFS_STEP * (N_CH - 1);

   if (SAMP_W < 4 || SAMP_W > 24) begin : g_bad_width
      $error("SAMP_W must lie in 4..24");
   end
   if (SHIFT_K < 1 || SHIFT_K > 24) begin : g_bad_shift
      $error("SHIFT_K must lie in 1..24");
   end
   if (LAST_OFS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the channel offsets");
   end

   logic [SAMP_W-1:0] x_arr [N_CH];
   logic [SAMP_W-1:0] y_arr [N_CH];
   logic [VAL_W-1:0]  e_arr [N_CH];
   logic              ov_q;

   assign x_arr[0] = in_i;
   assign x_arr[1] = in_q;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      dcoc_chan #(
         .SAMP_W  (SAMP_W),
         .SHIFT_K (SHIFT_K),
         .ADDR_W  (ADDR_W),
         .MY_ADDR (ADDR_W'(OFS_FIRST + OFS_STEP * c))
      ) u_ch (
         .clk       (clk),
         .rst       (rst),
         .cfg_we    (cfg_we),
         .cfg_addr  (cfg_addr),
         .cfg_wdata (cfg_wdata),
         .in_valid  (in_valid),
         .in_x      (x_arr[c]),
         .out_x     (y_arr[c]),
         .est       (e_arr[c])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) ov_q <= 1'b0;
      else     ov_q <= in_valid;
   end

   assign out_valid = ov_q;
   assign out_i     = y_arr[0];
   assign out_q     = y_arr[1];
   assign est_i     = e_arr[0];
   assign est_q     = e_arr[1];

   assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_valid_fall_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
endmodule

// File: tb/sim_rx_dc_corrector.sv
module sim_rx_dc_corrector;
   localparam int W = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [W-1:0] in_i = '0, in_q = '0;
   logic        out_valid;
   logic [W-1:0] out_i, out_q;
   logic [29:0] est_i, est_q;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   longint m_est [2];
   bit     m_fix [2];
   longint m_out [2];
   bit     m_ov;

   always #4 clk = ~clk;

   rx_dc_corrector u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
      .est_i(est_i), .est_q(est_q)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic longint e_dut(input int c);
      return (c == 0) ? longint'(signed'(est_i)) : longint'(signed'(est_q));
   endfunction

   function automatic longint o_dut(input int c);
      return (c == 0) ? longint'(signed'(out_i)) : longint'(signed'(out_q));
   endfunction

   // one clock: drive, advance the model, then compare at the falling edge
   task automatic cyc(input bit we, input int addr, input logic [31:0] data,
                      input bit v, input int xi, input int xq, input string tag);
      longint x, nxt, r, y;
      bit hit, f, s;
      cfg_we = we; cfg_addr = 5'(addr); cfg_wdata = data;
      in_valid = v; in_i = W'(xi); in_q = W'(xq);
      for (int c = 0; c < 2; c++) begin
         x   = (c == 0) ? longint'(xi) : longint'(xq);
         hit = we && (addr == 8 + 4 * c);
         f   = data[31];
         s   = data[30];
         if (v) begin
            r = (m_est[c] + 8192) >>> 14;
            y = x - r;
            if (y > 32767)  y = 32767;
            if (y < -32768) y = -32768;
            m_out[c] = y;
         end
         nxt = m_est[c];
         if (hit && f && s) nxt = longint'(signed'(data[29:0]));
         else if (v && !m_fix[c] && !(hit && f))
            nxt = m_est[c] + ((x * 16384 - m_est[c]) >>> 12);
         m_est[c] = nxt;
         if (hit) m_fix[c] = f;
      end
      m_ov = v;
      @(posedge clk);
      @(negedge clk);
      check(out_valid == m_ov, {tag, " valid R7"}, longint'(out_valid), longint'(m_ov));
      for (int c = 0; c < 2; c++) begin
         check(e_dut(c) == m_est[c], {tag, " est"}, e_dut(c), m_est[c]);
         if (m_ov) check(o_dut(c) == m_out[c], {tag, " out"}, o_dut(c), m_out[c]);
      end
   endtask

   logic [15:0] lfsr = 16'hACE1;
   function automatic int nextr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return int'(signed'(lfsr));
   endfunction

   initial begin
      #1_200_000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      longint frozen;
      for (int c = 0; c < 2; c++) begin m_est[c] = 0; m_fix[c] = 0; m_out[c] = 0; end
      m_ov = 0;
      repeat (3) @(negedge clk);
      // R2: state during reset
      check(est_i == 0 && est_q == 0, "R2 est in reset", longint'(est_i), 0);
      check(out_valid == 0, "R2 valid in reset", longint'(out_valid), 0);
      rst = 1'b0;
      @(negedge clk);
      check(est_i == 0 && est_q == 0, "R2 est after reset", longint'(est_i), 0);
      check(out_valid == 0, "R2 valid after reset", longint'(out_valid), 0);

      // R5/R9: constant bias, positive on I and negative on Q
      for (int k = 0; k < 48000; k++) cyc(0, 0, 0, 1, 1000, -2000, "R5 track");
      check(o_dut(0) == 0, "R9 I settles", o_dut(0), 0);
      check(o_dut(1) == 0, "R9 Q settles", o_dut(1), 0);
      check(((e_dut(0) + 8192) >>> 14) == 1000, "R9 I estimate", (e_dut(0) + 8192) >>> 14, 1000);

      // R6/R7: varied samples with gaps
      for (int k = 0; k < 300; k++) cyc(0, 0, 0, (k % 3) != 0, nextr(), nextr(), "R6 R7 mixed");

      // R4/R10: freeze I with a non-zero value field, Q keeps tracking
      frozen = e_dut(0);
      cyc(1, 8, 32'h8000_1234, 1, 500, 700, "R4 freeze write");
      for (int k = 0; k < 200; k++) cyc(0, 0, 0, 1, nextr(), 3000, "R4 R10 frozen");
      check(e_dut(0) == frozen, "R4 I held", e_dut(0), frozen);
      check(e_dut(1) != frozen, "R10 Q moved", e_dut(1), frozen);

      // R3/R8: loads at both ends of full scale
      cyc(1, 8, 32'hE000_0000, 0, 0, 0, "R3 load -1.0");
      check(e_dut(0) == -(64'sd1 <<< 29), "R3 loaded min", e_dut(0), -(64'sd1 <<< 29));
      cyc(0, 0, 0, 1, 32767, 0, "R8 clamp high");
      check(o_dut(0) == 32767, "R8 clamp high", o_dut(0), 32767);
      cyc(1, 8, 32'hDFFF_FFFF, 0, 0, 0, "R3 load max");
      check(e_dut(0) == (64'sd1 <<< 29) - 1, "R3 loaded max", e_dut(0), (64'sd1 <<< 29) - 1);
      cyc(0, 0, 0, 1, -32768, 0, "R8 clamp low");
      check(o_dut(0) == -32768, "R8 clamp low", o_dut(0), -32768);
      cyc(0, 0, 0, 1, 100, 0, "R7 in range");
      check(o_dut(0) == 100 - 32768, "R7 no clamp", o_dut(0), 100 - 32768);

      // R1: writes to neighbouring offsets are ignored
      frozen = e_dut(0);
      cyc(1, 16, 32'hC000_0100, 0, 0, 0, "R1 addr 16");
      cyc(1, 4, 32'h0000_0000, 0, 0, 0, "R1 addr 4");
      for (int k = 0; k < 20; k++) cyc(0, 0, 0, 1, 5, 5, "R1 still fixed");
      check(e_dut(0) == frozen, "R1 I untouched", e_dut(0), frozen);

      // R10: load and sample on Q in the same cycle
      cyc(1, 12, 32'hC000_4000, 1, 9, 9000, "R10 same cycle");
      check(e_dut(1) == 64'sh4000, "R10 load wins", e_dut(1), 64'sh4000);

      // R5: back to tracking from a loaded value
      cyc(1, 8, 32'h0000_0000, 1, -300, 0, "R5 auto again");
      for (int k = 0; k < 200; k++) cyc(0, 0, 0, 1, -300, nextr(), "R5 retrack");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule